// File: doc/BRIEF.md
# Text Contrast Remapper with Mono Threshold

This block is a colour-mapping pipeline stage for a gray-scale flat panel. Each valid cycle carries one pixel, marked either as text or as graphics. A text pixel holds a 4-bit foreground intensity and a 4-bit background intensity. When contrast mapping is on and the two intensities are too close, the stage pushes them apart. The brighter one moves up by its programmed step and the dimmer one moves down by its own step. The results then either wrap modulo 16 or saturate at the ends of the range. An optional enhanced-text mode swaps foreground codes 7h and Fh before the contrast test.

A graphics pixel holds a 6-bit colour. The stage reduces it to one bit by comparing it with a programmable threshold. Text output and graphics output each have their own polarity control.

The settings arrive as static register fields. The block copies them into a shadow register only in cycles that carry no pixel, so every pixel is processed with one consistent set of settings. The result appears two clock cycles after the pixel enters, and the valid and text tags travel with it.

Top module: `contrast_mapper_top`

## Requirements
- R1: `out_valid` and `out_text` equal `in_valid` and `in_text` from two rising edges earlier. In any cycle where `out_valid` is 0, `out_fg`, `out_bg` and `out_mono` are all 0.
- R2: The shadow settings load from the cfg inputs only on an edge where `in_valid` is 0, and reset to all zero. A change on the cfg inputs while pixels flow therefore takes effect only after the next idle cycle.
- R3: A text pixel is spread only when `cfg_map_en` is 1 and |fg − bg| is strictly less than `cfg_spread_thr`. A difference equal to the threshold leaves both values unchanged.
- R4: When a text pixel is spread, the brighter value rises by its own step and the dimmer value falls by its own step. The foreground always uses `cfg_fg_step` and the background always uses `cfg_bg_step`. When fg equals bg, the foreground is the one that rises.
- R5: With `cfg_wrap` = 1, spread results are taken modulo 16.
- R6: With `cfg_wrap` = 0, spread results clamp to 0 and 15.
- R7: With `cfg_map_en` = 1 and `cfg_enh_text` = 1, a foreground of 7 is treated as 15 and a foreground of 15 as 7, before the contrast test. The background is not swapped.
- R8: With `cfg_map_en` = 0, text fg and bg pass through unchanged, apart from the R10 polarity.
- R9: A graphics pixel gives `out_mono` = 1 when `in_color` >= `cfg_mono_thr`, and 0 otherwise.
- R10: `cfg_gfx_inv` = 1 inverts `out_mono` for graphics pixels. `cfg_text_inv` = 1 replaces the text outputs with 15 − fg and 15 − bg, applied after spreading.
- R11: A valid graphics pixel drives `out_fg` and `out_bg` to 0. A valid text pixel drives `out_mono` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_text | input | 1 | 1 = text pixel, 0 = graphics pixel |
| in_fg | input | 4 | Text foreground intensity |
| in_bg | input | 4 | Text background intensity |
| in_color | input | 6 | Graphics colour |
| cfg_map_en | input | 1 | Contrast mapping enable |
| cfg_spread_thr | input | 4 | Minimum contrast threshold |
| cfg_fg_step | input | 4 | Foreground shift in levels |
| cfg_bg_step | input | 4 | Background shift in levels |
| cfg_wrap | input | 1 | 1 = wrap modulo 16, 0 = clamp |
| cfg_enh_text | input | 1 | Swap foreground codes 7h and Fh |
| cfg_text_inv | input | 1 | Text output polarity |
| cfg_mono_thr | input | 6 | Graphics mono threshold |
| cfg_gfx_inv | input | 1 | Graphics output polarity |
| out_valid | output | 1 | Result present |
| out_text | output | 1 | Result is a text pixel |
| out_fg | output | 4 | Mapped foreground |
| out_bg | output | 4 | Mapped background |
| out_mono | output | 1 | Mono graphics bit |

## Verification
Two actions can meet on the same pixel. The first is a settings change, which can arrive in the same cycle as a pixel that must still use the old settings. The second is the spread itself, which can saturate or wrap in the same cycle that the swap and the polarity inversion also act on it. The bench provokes the first by changing the cfg inputs while pixels stream back to back. It provokes the second by driving intensities at the ends of the range with the swap and inversion turned on. A behavioural reference model receives the same inputs. It latches its own copy of the settings only on idle edges and computes each pixel with integer arithmetic. Every output is compared with that model on every clock.

// File: rtl/contrast_map_pkg.sv
package contrast_map_pkg;
    localparam int LVL_W   = 4;
    localparam int GRAY_W  = 6;
    localparam int LVL_MAX = (1 << LVL_W) - 1;
    localparam int SWAP_LO = LVL_MAX >> 1;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [GRAY_W-1:0] gray_t;

    typedef struct packed {
        logic  map_en;
        lvl_t  spread_thr;
        lvl_t  fg_step;
        lvl_t  bg_step;
        logic  wrap;
        logic  enh_text;
        logic  text_inv;
        gray_t mono_thr;
        logic  gfx_inv;
    } cfg_t;

    typedef struct packed {
        logic valid;
        logic text;
        lvl_t fg;
        lvl_t bg;
        logic spread;
        logic fg_up;
        logic mono_raw;
        lvl_t fg_step;
        lvl_t bg_step;
        logic wrap;
        logic text_inv;
        logic gfx_inv;
    } stage_t;

    typedef struct packed {
        logic valid;
        logic text;
        lvl_t fg;
        lvl_t bg;
        logic mono;
    } result_t;

    function automatic lvl_t lvl_raise(lvl_t v, lvl_t s, logic wrap);
        logic [LVL_W:0] sum;
        sum = {1'b0, v} + {1'b0, s};
        if (wrap || !sum[LVL_W]) return sum[LVL_W-1:0];
        return lvl_t'(LVL_MAX);
    endfunction

    function automatic lvl_t lvl_lower(lvl_t v, lvl_t s, logic wrap);
        logic [LVL_W:0] dif;
        dif = {1'b0, v} - {1'b0, s};
        if (wrap || !dif[LVL_W]) return dif[LVL_W-1:0];
        return '0;
    endfunction
endpackage

// File: rtl/cm_cfg_shadow.sv
module cm_cfg_shadow
    import contrast_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (!busy) cfg_d = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/cm_decide.sv
module cm_decide
    import contrast_map_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  logic   in_text,
    input  lvl_t   in_fg,
    input  lvl_t   in_bg,
    input  gray_t  in_color,
    input  cfg_t   cfg,
    output stage_t stage_q
);
    stage_t stage_d;
    lvl_t   fg_eff;
    lvl_t   gap;
    logic   fg_ge;

    always_comb begin
        fg_eff = in_fg;
        if (cfg.map_en && cfg.enh_text) begin
            if (in_fg == lvl_t'(SWAP_LO))      fg_eff = lvl_t'(LVL_MAX);
            else if (in_fg == lvl_t'(LVL_MAX)) fg_eff = lvl_t'(SWAP_LO);
        end
        fg_ge = (fg_eff >= in_bg);
        gap   = fg_ge ? (fg_eff - in_bg) : (in_bg - fg_eff);

        stage_d = '0;
        if (in_valid) begin
            stage_d.valid    = 1'b1;
            stage_d.text     = in_text;
            stage_d.fg_step  = cfg.fg_step;
            stage_d.bg_step  = cfg.bg_step;
            stage_d.wrap     = cfg.wrap;
            stage_d.text_inv = cfg.text_inv;
            stage_d.gfx_inv  = cfg.gfx_inv;
            if (in_text) begin
                stage_d.fg     = fg_eff;
                stage_d.bg     = in_bg;
                stage_d.spread = cfg.map_en && (gap < cfg.spread_thr);
                stage_d.fg_up  = fg_ge;
            end else begin
                stage_d.mono_raw = (in_color >= cfg.mono_thr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/cm_apply.sv
module cm_apply
    import contrast_map_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  stage_t  stage,
    output result_t res_q
);
    result_t res_d;
    lvl_t    fg_n;
    lvl_t    bg_n;

    always_comb begin
        fg_n = stage.fg;
        bg_n = stage.bg;
        if (stage.spread) begin
            if (stage.fg_up) begin
                fg_n = lvl_raise(stage.fg, stage.fg_step, stage.wrap);
                bg_n = lvl_lower(stage.bg, stage.bg_step, stage.wrap);
            end else begin
                fg_n = lvl_lower(stage.fg, stage.fg_step, stage.wrap);
                bg_n = lvl_raise(stage.bg, stage.bg_step, stage.wrap);
            end
        end
        if (stage.text_inv) begin
            fg_n = ~fg_n;
            bg_n = ~bg_n;
        end

        res_d = '0;
        if (stage.valid) begin
            res_d.valid = 1'b1;
            res_d.text  = stage.text;
            if (stage.text) begin
                res_d.fg = fg_n;
                res_d.bg = bg_n;
            end else begin
                res_d.mono = stage.mono_raw ^ stage.gfx_inv;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end
endmodule

// File: rtl/contrast_mapper_top.sv
module contrast_mapper_top
    import contrast_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_text,
    input  logic [LVL_W-1:0]  in_fg,
    input  logic [LVL_W-1:0]  in_bg,
    input  logic [GRAY_W-1:0] in_color,
    input  logic              cfg_map_en,
    input  logic [LVL_W-1:0]  cfg_spread_thr,
    input  logic [LVL_W-1:0]  cfg_fg_step,
    input  logic [LVL_W-1:0]  cfg_bg_step,
    input  logic              cfg_wrap,
    input  logic              cfg_enh_text,
    input  logic              cfg_text_inv,
    input  logic [GRAY_W-1:0] cfg_mono_thr,
    input  logic              cfg_gfx_inv,
    output logic              out_valid,
    output logic              out_text,
    output logic [LVL_W-1:0]  out_fg,
    output logic [LVL_W-1:0]  out_bg,
    output logic              out_mono
);
    cfg_t    cfg_in;
    cfg_t    cfg_live;
    stage_t  stage;
    result_t res;

    always_comb begin
        cfg_in.map_en     = cfg_map_en;
        cfg_in.spread_thr = cfg_spread_thr;
        cfg_in.fg_step    = cfg_fg_step;
        cfg_in.bg_step    = cfg_bg_step;
        cfg_in.wrap       = cfg_wrap;
        cfg_in.enh_text   = cfg_enh_text;
        cfg_in.text_inv   = cfg_text_inv;
        cfg_in.mono_thr   = cfg_mono_thr;
        cfg_in.gfx_inv    = cfg_gfx_inv;
    end

    cm_cfg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (in_valid),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_live)
    );

    cm_decide u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_text  (in_text),
        .in_fg    (in_fg),
        .in_bg    (in_bg),
        .in_color (in_color),
        .cfg      (cfg_live),
        .stage_q  (stage)
    );

    cm_apply u_apply (
        .clk   (clk),
        .rst_n (rst_n),
        .stage (stage),
        .res_q (res)
    );

    assign out_valid = res.valid;
    assign out_text  = res.text;
    assign out_fg    = res.fg;
    assign out_bg    = res.bg;
    assign out_mono  = res.mono;
endmodule

// File: rtl/contrast_mapper_chk.sv
module contrast_mapper_chk
    import contrast_map_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  in_valid,
    input logic  in_text,
    input lvl_t  in_fg,
    input lvl_t  in_bg,
    input logic  out_valid,
    input logic  out_text,
    input lvl_t  out_fg,
    input lvl_t  out_bg,
    input logic  out_mono,
    input cfg_t  cfg_live
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));                  // R1
    AST_TEXT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid) |-> (out_text == $past(in_text, 2)));       // R1
    AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_fg == '0 && out_bg == '0 && !out_mono));           // R1
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && in_valid) |=> $stable(cfg_live));                      // R2
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid && out_text && !$past(cfg_live.map_en, 2)
         && !$past(cfg_live.text_inv, 2))
        |-> (out_fg == $past(in_fg, 2) && out_bg == $past(in_bg, 2)));         // R8
    AST_GFX_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_text) |-> (out_fg == '0 && out_bg == '0));          // R11
    AST_TEXT_MONO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_text) |-> !out_mono);                                // R11
endmodule

bind contrast_mapper_top contrast_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_text   (in_text),
    .in_fg     (in_fg),
    .in_bg     (in_bg),
    .out_valid (out_valid),
    .out_text  (out_text),
    .out_fg    (out_fg),
    .out_bg    (out_bg),
    .out_mono  (out_mono),
    .cfg_live  (cfg_live)
);

// File: tb/tb_contrast_mapper_top.sv
`timescale 1ns/1ps
module tb_contrast_mapper_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_text = 1'b0;
    logic [3:0] in_fg = '0, in_bg = '0;
    logic [5:0] in_color = '0;
    logic       cfg_map_en = 1'b0;
    logic [3:0] cfg_spread_thr = '0, cfg_fg_step = '0, cfg_bg_step = '0;
    logic       cfg_wrap = 1'b0, cfg_enh_text = 1'b0, cfg_text_inv = 1'b0;
    logic [5:0] cfg_mono_thr = '0;
    logic       cfg_gfx_inv = 1'b0;
    logic       out_valid, out_text, out_mono;
    logic [3:0] out_fg, out_bg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    contrast_mapper_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_text(in_text),
        .in_fg(in_fg), .in_bg(in_bg), .in_color(in_color),
        .cfg_map_en(cfg_map_en), .cfg_spread_thr(cfg_spread_thr),
        .cfg_fg_step(cfg_fg_step), .cfg_bg_step(cfg_bg_step),
        .cfg_wrap(cfg_wrap), .cfg_enh_text(cfg_enh_text),
        .cfg_text_inv(cfg_text_inv), .cfg_mono_thr(cfg_mono_thr),
        .cfg_gfx_inv(cfg_gfx_inv), .out_valid(out_valid), .out_text(out_text),
        .out_fg(out_fg), .out_bg(out_bg), .out_mono(out_mono)
    );

    // reference model: shadow copy of settings plus a two-deep result queue
    int    m_en, m_thr, m_fs, m_bs, m_wrap, m_enh, m_tinv, m_mthr, m_ginv;
    int    q_valid[$], q_text[$], q_fg[$], q_bg[$], q_mono[$];
    string q_tag[$];

    function automatic int clamp16(int v, int wrap);
        if (wrap != 0) return v & 15;        // R5
        if (v > 15) return 15;               // R6
        if (v < 0) return 0;
        return v;
    endfunction

    task automatic model_push();
        int v = 0, t = 0, f = 0, b = 0, m = 0, d = 0;
        string tag = "R1";
        if (in_valid) begin
            v = 1; t = in_text;
            if (in_text) begin
                f = in_fg; b = in_bg; tag = "R11";
                if (m_en != 0 && m_enh != 0 && (f == 7 || f == 15)) begin
                    f = (f == 7) ? 15 : 7; tag = {tag, " R7"};
                end
                d = (f > b) ? f - b : b - f;
                if (m_en == 0) tag = {tag, " R8"};
                if (m_en != 0 && d < m_thr) begin
                    tag = {tag, " R3 R4", (m_wrap != 0) ? " R5" : " R6"};
                    if (f >= b) begin f = clamp16(f + m_fs, m_wrap); b = clamp16(b - m_bs, m_wrap); end
                    else        begin f = clamp16(f - m_fs, m_wrap); b = clamp16(b + m_bs, m_wrap); end
                end else if (m_en != 0) tag = {tag, " R3"};
                if (m_tinv != 0) begin f = 15 - f; b = 15 - b; tag = {tag, " R10"}; end
            end else begin
                m = (int'(in_color) >= m_mthr) ? 1 : 0; tag = "R9 R11";
                if (m_ginv != 0) begin m = 1 - m; tag = {tag, " R10"}; end
            end
        end
        q_valid.push_back(v); q_text.push_back(t); q_fg.push_back(f);
        q_bg.push_back(b); q_mono.push_back(m); q_tag.push_back(tag);
        // R2: settings copied only on an idle edge
        if (!in_valid) begin
            m_en = cfg_map_en; m_thr = cfg_spread_thr; m_fs = cfg_fg_step;
            m_bs = cfg_bg_step; m_wrap = cfg_wrap; m_enh = cfg_enh_text;
            m_tinv = cfg_text_inv; m_mthr = cfg_mono_thr; m_ginv = cfg_gfx_inv;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_thr = 0; m_fs = 0; m_bs = 0; m_wrap = 0; m_enh = 0;
            m_tinv = 0; m_mthr = 0; m_ginv = 0;
            q_valid = {0, 0}; q_text = {0, 0}; q_fg = {0, 0}; q_bg = {0, 0};
            q_mono = {0, 0}; q_tag = {"R1 R2", "R1 R2"};
        end else begin
            model_push();
            void'(q_valid.pop_front()); void'(q_text.pop_front());
            void'(q_fg.pop_front()); void'(q_bg.pop_front());
            void'(q_mono.pop_front()); void'(q_tag.pop_front());
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R1 R2", "reset out_valid", int'(out_valid), 0);
            end else begin
                check("R1", "out_valid", int'(out_valid), q_valid[0]);
                check("R1", "out_text", int'(out_text), q_text[0]);
                check(q_tag[0], "out_fg", int'(out_fg), q_fg[0]);
                check(q_tag[0], "out_bg", int'(out_bg), q_bg[0]);
                check(q_tag[0], "out_mono", int'(out_mono), q_mono[0]);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_text = 1'b0; in_fg = '0; in_bg = '0; in_color = '0;
        end
    endtask

    task automatic txt(int f, int b);
        @(negedge clk);
        in_valid = 1'b1; in_text = 1'b1; in_fg = 4'(f); in_bg = 4'(b); in_color = '0;
    endtask

    task automatic gfx(int c);
        @(negedge clk);
        in_valid = 1'b1; in_text = 1'b0; in_fg = '0; in_bg = '0; in_color = 6'(c);
    endtask

    task automatic setcfg(int en, int thr, int fs, int bs, int wr, int enh,
                          int ti, int mt, int gi);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_map_en = 1'(en); cfg_spread_thr = 4'(thr); cfg_fg_step = 4'(fs);
        cfg_bg_step = 4'(bs); cfg_wrap = 1'(wr); cfg_enh_text = 1'(enh);
        cfg_text_inv = 1'(ti); cfg_mono_thr = 6'(mt); cfg_gfx_inv = 1'(gi);
    endtask

    task automatic spread_set();
        txt(5, 6); txt(14, 13); txt(1, 2); txt(8, 8); txt(10, 3);
        txt(9, 5); txt(0, 0); txt(15, 15); txt(2, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R8: mapping off, text passes through
        setcfg(0, 15, 3, 2, 0, 1, 0, 0, 0);
        spread_set(); txt(7, 0); idle(3);
        // R3 R4 R6: spread with clamping, gap equal to threshold untouched
        setcfg(1, 4, 3, 2, 0, 0, 0, 0, 0);
        spread_set(); idle(3);
        // R5: wrap modulo 16
        setcfg(1, 4, 3, 2, 1, 0, 0, 0, 0);
        spread_set(); idle(3);
        // R7: foreground 7/F swap before the contrast test
        setcfg(1, 2, 1, 1, 0, 1, 0, 0, 0);
        txt(7, 15); txt(15, 7); txt(7, 7); txt(15, 14); txt(6, 7); idle(3);
        // R10: text inversion on top of saturation
        setcfg(1, 8, 15, 15, 0, 1, 1, 0, 0);
        spread_set(); txt(7, 15); idle(3);
        // R9 R10: graphics threshold, both polarities
        setcfg(0, 0, 0, 0, 0, 0, 0, 32, 0);
        gfx(31); gfx(32); gfx(63); gfx(0); idle(1);
        setcfg(0, 0, 0, 0, 0, 0, 0, 32, 1);
        gfx(31); gfx(32); gfx(63); txt(3, 4); gfx(0); idle(3);
        // R2: settings change mid-stream must wait for an idle edge
        setcfg(1, 4, 3, 2, 0, 0, 0, 10, 0);
        txt(5, 6); txt(5, 6);
        cfg_wrap = 1'b1; cfg_text_inv = 1'b1; cfg_gfx_inv = 1'b1;
        txt(5, 6); gfx(12); txt(1, 2); idle(1); txt(1, 2); gfx(12); idle(3);
        // mixed random traffic with random settings changes
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                @(negedge clk);
                cfg_map_en = 1'($urandom); cfg_spread_thr = 4'($urandom);
                cfg_fg_step = 4'($urandom); cfg_bg_step = 4'($urandom);
                cfg_wrap = 1'($urandom); cfg_enh_text = 1'($urandom);
                cfg_text_inv = 1'($urandom); cfg_mono_thr = 6'($urandom);
                cfg_gfx_inv = 1'($urandom);
            end
            case ($urandom_range(0, 3))
                0: idle(1);
                1: gfx(int'($urandom_range(0, 63)));
                default: txt(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
            endcase
        end
        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule